// File: doc/BRIEF.md
# Toggle-Cell Memory Module

This block is one module of a bit-flip memory, an array of rows by columns in which every bit is a toggle flip-flop. No input loads data into the array. Each strobe inverts the cells chosen by three enables together: the module-active level, the row select and the per-column flip mask. To store a value, the controller first reads the row and then flips the bits that differ. To read a row, it flips every bit of that row and captures the result on the read bus.

Each row has one extra polarity flag that records whether the row is held inverted. The logical content of a row is its cells XOR its flag. A read can use two plain strobes, which invert the row and then restore it. It can also use one strobe that flips the flag together with the cells, so the logical content never changes. Each column of the read bus has a capture stage. That stage takes the logical value of its enabled column after the strobe and holds it until that column is enabled again. Address decoding and read/write sequencing belong to an outside controller.

The read bus is a plain level-held output with no valid/ready handshake. The array never stalls, so there is no back-pressure. The value on the bus stays until the next strobe that reaches the module.

Top module: `tglmem_module`

## Requirements
- R1: On reset every cell, every polarity flag and every capture stage is cleared to zero, so the read bus reads 0 and every row reads as logical 0.
- R2: A strobe with module-active high inverts only the cells of the selected row whose mask bit is 1. Mask bit c acts on read-bus bit c.
- R3: When module-active is low, a strobe changes no cell, no flag and no read-bus bit.
- R4: A strobe changes no cell and no flag in any row whose select bit is 0.
- R5: On an effective strobe, read-bus bit c, for each column with mask bit 1, takes the logical value (cell XOR flag) of the selected row after that strobe. This is visible after the same clock edge.
- R6: Read-bus bits whose mask bit is 0, and every read-bus bit between effective strobes, keep their last captured value.
- R7: An effective strobe with the flip-polarity input high also inverts the row's flag. With an all-ones mask, this gives a single-strobe read that returns the true row value and leaves the row's logical content unchanged.
- R8: Two plain strobes with an all-ones mask restore the row's logical content, and the read bus then shows that content.
- R9: The row-select vector has at most one bit set whenever the strobe is high. This is a rule for the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_sel | input | ROWS | One-hot row select |
| col_mask | input | COLS | Per-column flip enables |
| mod_act | input | 1 | Module-active gate for all row and column enables |
| tgl_stb | input | 1 | Toggle strobe, one cycle per pulse |
| flip_pol | input | 1 | Also invert the selected row's polarity flag |
| rd_data | output | COLS | Read bus held by the column capture stages |

## Verification
The bench builds the block with the default 8 rows by 8 columns. At that size, rows 0 and 7 at the two ends of the array and full-width masks can be checked against hand-worked values. A single-strobe read is followed by a two-strobe read of the same row, so a flag that failed to flip would show up as corrupted data. Gated strobes, a zero mask, partial masks that leave other capture bits in place, and a reset in the middle of the run are each followed by a read through the bus.

// File: rtl/tglmem_pkg.sv
package tglmem_pkg;
  localparam int unsigned TGL_ROWS_DEF = 8;
  localparam int unsigned TGL_COLS_DEF = 8;
endpackage

// File: rtl/tglmem_gate.sv
module tglmem_gate #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 8
) (
  input  logic            mod_act,
  input  logic            tgl_stb,
  input  logic [ROWS-1:0] row_sel,
  input  logic [COLS-1:0] col_mask,
  output logic [ROWS-1:0] row_go,
  output logic [COLS-1:0] col_go,
  output logic            any_go
);
  // module-active feeds both the row and the column gates
  assign row_go = row_sel & {ROWS{mod_act & tgl_stb}};
  assign col_go = col_mask & {COLS{mod_act}};
  assign any_go = |row_go;
endmodule

// File: rtl/tglmem_row.sv
module tglmem_row #(
  parameter int unsigned COLS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            row_go,
  input  logic [COLS-1:0] col_go,
  input  logic            flip_pol,
  output logic [COLS-1:0] cells,
  output logic            pol
);
  for (genvar c = 0; c < COLS; c++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)                  cells[c] <= 1'b0;
      else if (row_go && col_go[c]) cells[c] <= ~cells[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   pol <= 1'b0;
    else if (row_go && flip_pol)  pol <= ~pol;
  end

  // R4: a row without its go signal keeps cells and flag
  p_row_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !row_go |=> ($stable(cells) && $stable(pol)));

  // R7: a flip request inverts the flag
  p_flag_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (row_go && flip_pol) |=> (pol != $past(pol)));

  // R2: full-mask strobe inverts every cell of the row
  p_full_invert_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_go && (col_go == {COLS{1'b1}})) |=> (cells == ~$past(cells)));
endmodule

// File: rtl/tglmem_capture.sv
module tglmem_capture #(
  parameter int unsigned COLS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_go,
  input  logic [COLS-1:0] col_go,
  input  logic [COLS-1:0] next_val,
  output logic [COLS-1:0] rd_data
);
  for (genvar c = 0; c < COLS; c++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rst_n)                   rd_data[c] <= 1'b0;
      else if (any_go && col_go[c]) rd_data[c] <= next_val[c];
    end
  end

  // R6: no effective strobe, no change on the bus
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !any_go |=> $stable(rd_data));
endmodule

// File: rtl/tglmem_module.sv
module tglmem_module
  import tglmem_pkg::*;
#(
  parameter int unsigned ROWS = TGL_ROWS_DEF,
  parameter int unsigned COLS = TGL_COLS_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] row_sel,
  input  logic [COLS-1:0] col_mask,
  input  logic            mod_act,
  input  logic            tgl_stb,
  input  logic            flip_pol,
  output logic [COLS-1:0] rd_data
);
  logic [ROWS-1:0] row_go;
  logic [COLS-1:0] col_go;
  logic            any_go;
  logic [COLS-1:0] row_bits [ROWS];
  logic [ROWS-1:0] row_pol;
  logic [COLS-1:0] sel_bits;
  logic            sel_pol;
  logic [COLS-1:0] next_val;

  tglmem_gate #(.ROWS(ROWS), .COLS(COLS)) gate_i (
    .mod_act (mod_act),
    .tgl_stb (tgl_stb),
    .row_sel (row_sel),
    .col_mask(col_mask),
    .row_go  (row_go),
    .col_go  (col_go),
    .any_go  (any_go)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    tglmem_row #(.COLS(COLS)) row_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .row_go  (row_go[r]),
      .col_go  (col_go),
      .flip_pol(flip_pol),
      .cells   (row_bits[r]),
      .pol     (row_pol[r])
    );
  end

  // OR-select of the addressed row (one-hot select)
  always_comb begin
    sel_bits = '0;
    sel_pol  = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_sel[r]) begin
        sel_bits = sel_bits | row_bits[r];
        sel_pol  = sel_pol | row_pol[r];
      end
    end
  end

  // logical value of the row after this strobe: toggled cells XOR updated flag
  assign next_val = (sel_bits ^ col_go) ^ {COLS{sel_pol ^ flip_pol}};

  tglmem_capture #(.COLS(COLS)) cap_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_go  (any_go),
    .col_go  (col_go),
    .next_val(next_val),
    .rd_data (rd_data)
  );

  // R9: controller keeps the row select one-hot while strobing
  p_onehot_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_stb |-> $onehot0(row_sel));

  // R3: a parked module leaves the read bus untouched
  p_parked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_act |=> $stable(rd_data));

  // R6: unmasked columns keep their captured bit
  p_unmasked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_mask == '0) |=> $stable(rd_data));
endmodule

// File: tb/tglmem_module_tb_top.sv
`timescale 1ns/1ps
module tglmem_module_tb_top;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int NVEC = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [ROWS-1:0] row_sel = '0;
  logic [COLS-1:0] col_mask = '0;
  logic            mod_act = 1'b0;
  logic            tgl_stb = 1'b0;
  logic            flip_pol = 1'b0;
  logic [COLS-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tglmem_module #(.ROWS(ROWS), .COLS(COLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .col_mask(col_mask),
    .mod_act(mod_act), .tgl_stb(tgl_stb), .flip_pol(flip_pol), .rd_data(rd_data)
  );

  // {row[2:0], mask[7:0], mod, flip, expected bus[7:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {3'd2, 8'hA5, 1'b1, 1'b0, 8'hA5},  // R2 R5 write row 2
    {3'd5, 8'h3C, 1'b1, 1'b0, 8'hBD},  // R5 R6 partial mask keeps other bits
    {3'd2, 8'hFF, 1'b0, 1'b0, 8'hBD},  // R3 parked strobe ignored
    {3'd2, 8'hFF, 1'b1, 1'b0, 8'h5A},  // R8 first read strobe
    {3'd2, 8'hFF, 1'b1, 1'b0, 8'hA5},  // R8 second read strobe restores
    {3'd5, 8'hFF, 1'b1, 1'b1, 8'h3C},  // R7 single-strobe read
    {3'd5, 8'hFF, 1'b1, 1'b0, 8'hC3},  // R7 follow-up read, strobe 1
    {3'd5, 8'hFF, 1'b1, 1'b0, 8'h3C},  // R7 R8 content intact
    {3'd0, 8'h0F, 1'b1, 1'b0, 8'h3F},  // R2 row 0 low nibble
    {3'd7, 8'hF0, 1'b0, 1'b1, 8'h3F},  // R3 parked flip ignored
    {3'd7, 8'hF0, 1'b1, 1'b1, 8'h0F},  // R7 flip with partial mask
    {3'd7, 8'hFF, 1'b1, 1'b0, 8'hF0},  // R8 read row 7 strobe 1
    {3'd7, 8'hFF, 1'b1, 1'b0, 8'h0F},  // R8 read row 7 strobe 2
    {3'd0, 8'h00, 1'b1, 1'b0, 8'h0F},  // R6 zero mask
    {3'd2, 8'hFF, 1'b1, 1'b0, 8'h5A},  // R4 row 2 untouched by others
    {3'd2, 8'hFF, 1'b1, 1'b0, 8'hA5}   // R4 R8 row 2 restored
  };

  task automatic check(input string req, input logic [COLS-1:0] act, input logic [COLS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input int row, input logic [COLS-1:0] m, input logic ma, input logic fp);
    @(negedge clk);
    row_sel  = ROWS'(1) << row;
    col_mask = m;
    mod_act  = ma;
    flip_pol = fp;
    tgl_stb  = 1'b1;
    @(negedge clk);
    tgl_stb  = 1'b0;
    mod_act  = 1'b0;
    flip_pol = 1'b0;
    col_mask = '0;
    row_sel  = '0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset bus", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bus after release", rd_data, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      pulse(int'(VEC[i][20:18]), VEC[i][17:10], VEC[i][9], VEC[i][8]);
      check($sformatf("vector %0d", i), rd_data, VEC[i][7:0]);
    end

    // R6: idle cycles keep the bus
    repeat (4) @(negedge clk);
    check("R6 idle hold", rd_data, 8'hA5);

    // R4: row 5 still holds 3C after activity on other rows
    pulse(5, 8'hFF, 1'b1, 1'b0);
    check("R4 row 5 strobe 1", rd_data, 8'hC3);
    pulse(5, 8'hFF, 1'b1, 1'b0);
    check("R4 row 5 strobe 2", rd_data, 8'h3C);

    // R1: mid-run reset clears cells and flags
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset bus", rd_data, 8'h00);
    rst_n = 1'b1;
    pulse(2, 8'hFF, 1'b1, 1'b0);
    check("R1 row 2 cleared strobe 1", rd_data, 8'hFF);
    pulse(2, 8'hFF, 1'b1, 1'b0);
    check("R1 row 2 cleared strobe 2", rd_data, 8'h00);
    pulse(5, 8'hFF, 1'b1, 1'b1);
    check("R1 R7 row 5 flag cleared", rd_data, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule